// File: doc/BRIEF.md
# Pin Port with Per-Pin Interrupt Detection

A port of 32 general-purpose pins, each of which can be an input or can drive a bit of an output register. Software reaches the port through a register bus of single-cycle accesses, with valid, write, word address and data. A write completes on the clock edge. Read data follows the address combinationally. Two write-only aliases set or clear chosen output bits in one access, so that no read-modify-write is needed.

Every pin input passes through a two-flop synchronizer. A per-pin detector then looks for one of four conditions: low level, high level, rising edge or falling edge. A separate per-pin bit instead selects detection on any change of the pin. A detected condition latches into a status register, and software clears it by writing a 1 to the bit. A mask register decides which latched bits reach the single combined interrupt output.

Word addresses: 0 output data, 1 direction, 2 trigger config for pins 0-15, 3 trigger config for pins 16-31, 4 interrupt mask, 5 status, 6 any-edge select, 7 set alias, 8 clear alias.

Top module: `gpio_port`

## Requirements
- R1: During and right after reset, the output data, direction, both config words, mask, any-edge select and pin_oe_o are all 0, and irq_o is 0.
- R2: Direction bit i set to 1 makes pin_oe_o[i] 1, and pin_o follows the output data register on the edge that completes the write.
- R3: A write to the set alias (address 7) forces each output data bit to 1 where the write data has a 1. A write to the clear alias (address 8) forces it to 0 where the write data has a 1. Bits written 0 are unchanged.
- R4: Reads of the set and clear aliases return 0.
- R5: A read of address 0 returns the output data bit for pins whose direction bit is 1, and the synchronized pin level for pins whose direction bit is 0. A pin level reaches the read value two clock edges after it changes.
- R6: The trigger code of pin i sits at bits 2*(i mod 16)+1:2*(i mod 16) of address 2 for pins 0-15, and of address 3 for pins 16-31.
- R7: Code 00 detects low level and code 01 detects high level. A level that is still present sets its status bit again on the cycle after a clear.
- R8: Code 10 detects a rising edge only. One edge sets status once.
- R9: Code 11 detects a falling edge only.
- R10: Any-edge select bit i at 1 makes pin i detect both edges, and the code of pin i is ignored.
- R11: A status bit is set by its detected condition whatever the mask. Writing 1 to the bit at address 5 clears it, and writing 0 leaves it unchanged. A new event in the same cycle as a clear leaves the bit set.
- R12: irq_o is the OR over all pins of status AND mask. A mask bit of 0 blocks its pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| pin_i | input | 32 | Pin levels, asynchronous |
| pin_o | output | 32 | Output levels |
| pin_oe_o | output | 32 | Output enable per pin |
| irq_o | output | 1 | Combined interrupt |

## Verification
A status bit can see a software clear and a new event in the same cycle. The bench provokes this by holding a pin at an active high level and writing 1 to that pin's status bit. It reads status on the falling edge right after the write edge, before any later event could set the bit again, and expects the bit to still be 1. It also clears a bit after an edge event, with no new event present, and expects 0 in that position.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_mode_e;

  typedef enum logic [3:0] {
    A_DATA   = 4'd0,
    A_DIR    = 4'd1,
    A_CFG_LO = 4'd2,
    A_CFG_HI = 4'd3,
    A_MASK   = 4'd4,
    A_STAT   = 4'd5,
    A_ANYEDG = 4'd6,
    A_SET    = 4'd7,
    A_CLR    = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_port_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [2*N_PINS-1:0] cfg_i,
  input  logic [N_PINS-1:0] anyedge_i,
  input  logic [N_PINS-1:0] w1c_i,
  output logic [N_PINS-1:0] status_o
);
  logic [N_PINS-1:0] prev_q, evt, status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    trig_mode_e mode;
    logic rise, fall;
    assign mode = trig_mode_e'(cfg_i[2*i +: 2]);
    assign rise = lvl_i[i] & ~prev_q[i];
    assign fall = ~lvl_i[i] & prev_q[i];
    always_comb begin
      if (anyedge_i[i]) evt[i] = rise | fall;
      else begin
        unique case (mode)
          TRIG_LOW:  evt[i] = ~lvl_i[i];
          TRIG_HIGH: evt[i] = lvl_i[i];
          TRIG_RISE: evt[i] = rise;
          default:   evt[i] = fall;
        endcase
      end
    end
  end

  // new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~w1c_i) | evt;
  end

  assign status_o = status_q;

  p_evt_latch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt)));
  p_w1c_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(w1c_i & ~evt)) |=> ((status_q & $past(w1c_i & ~evt)) == '0));
  p_anyedge_only_change_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt & anyedge_i & ~(lvl_i ^ prev_q)) == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int AW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [N_PINS-1:0] bus_wdata_i,
  output logic [N_PINS-1:0] bus_rdata_o,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] status_i,
  output logic [N_PINS-1:0] dout_o,
  output logic [N_PINS-1:0] dir_o,
  output logic [2*N_PINS-1:0] cfg_o,
  output logic [N_PINS-1:0] mask_o,
  output logic [N_PINS-1:0] anyedge_o,
  output logic [N_PINS-1:0] w1c_o
);
  logic [N_PINS-1:0] dout_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, anyedge_q;
  logic wr;
  reg_addr_e addr;

  assign wr   = bus_valid_i & bus_write_i;
  assign addr = reg_addr_e'(bus_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q    <= '0;
      dir_q     <= '0;
      cfg_lo_q  <= '0;
      cfg_hi_q  <= '0;
      mask_q    <= '0;
      anyedge_q <= '0;
    end else if (wr) begin
      case (addr)
        A_DATA:   dout_q    <= bus_wdata_i;
        A_SET:    dout_q    <= dout_q | bus_wdata_i;
        A_CLR:    dout_q    <= dout_q & ~bus_wdata_i;
        A_DIR:    dir_q     <= bus_wdata_i;
        A_CFG_LO: cfg_lo_q  <= bus_wdata_i;
        A_CFG_HI: cfg_hi_q  <= bus_wdata_i;
        A_MASK:   mask_q    <= bus_wdata_i;
        A_ANYEDG: anyedge_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  assign w1c_o = (wr && addr == A_STAT) ? bus_wdata_i : '0;

  always_comb begin
    case (addr)
      A_DATA:   bus_rdata_o = (dout_q & dir_q) | (lvl_i & ~dir_q);
      A_DIR:    bus_rdata_o = dir_q;
      A_CFG_LO: bus_rdata_o = cfg_lo_q;
      A_CFG_HI: bus_rdata_o = cfg_hi_q;
      A_MASK:   bus_rdata_o = mask_q;
      A_STAT:   bus_rdata_o = status_i;
      A_ANYEDG: bus_rdata_o = anyedge_q;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign dout_o    = dout_q;
  assign dir_o     = dir_q;
  assign cfg_o     = {cfg_hi_q, cfg_lo_q};
  assign mask_o    = mask_q;
  assign anyedge_o = anyedge_q;

  p_set_alias_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr == A_SET) |=> ((dout_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));
  p_clr_alias_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr == A_CLR) |=> ((dout_q & $past(bus_wdata_i)) == '0));
  p_alias_read_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr == A_SET || addr == A_CLR) |-> (bus_rdata_o == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int AW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [N_PINS-1:0] bus_wdata_i,
  output logic [N_PINS-1:0] bus_rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  logic [N_PINS-1:0]   lvl, status, dout, dir, mask, anyedge, w1c;
  logic [2*N_PINS-1:0] cfg;

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(lvl)
  );

  gpio_regs #(.N_PINS(N_PINS), .AW(AW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .lvl_i(lvl), .status_i(status),
    .dout_o(dout), .dir_o(dir), .cfg_o(cfg), .mask_o(mask),
    .anyedge_o(anyedge), .w1c_o(w1c)
  );

  gpio_irq_detect #(.N_PINS(N_PINS)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lvl_i(lvl), .cfg_i(cfg), .anyedge_i(anyedge),
    .w1c_i(w1c), .status_o(status)
  );

  assign pin_o    = dout;
  assign pin_oe_o = dir;
  assign irq_o    = |(status & mask);

  p_mask_blocks_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);
  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_addr_i == AW'(A_DIR)) |=> (pin_oe_o == $past(bus_wdata_i)));
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 pin_o, 3 pin_oe
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  gpio_port dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // monitor: compares pending items 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = rdata;
          1: act = {31'd0, irq};
          2: act = pin_out;
          default: act = pin_oe;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    valid = 1'b0; write = 1'b0; addr = a;
    push(0, exp, tag);
  endtask

  task automatic port(input int kind, input logic [31:0] exp, input string tag);
    @(negedge clk);
    push(kind, exp, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  // write, then read on the very next falling edge
  task automatic wr_rd(input logic [3:0] a, input logic [31:0] d,
                       input logic [3:0] ra, input logic [31:0] exp, input string tag);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; addr = ra;
    push(0, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state, checked while reset is held
    rd(4'd0, 32'h0, "R1 data");
    rd(4'd1, 32'h0, "R1 dir");
    rd(4'd4, 32'h0, "R1 mask");
    rd(4'd2, 32'h0, "R1 cfg_lo");
    rd(4'd6, 32'h0, "R1 anyedge");
    port(3, 32'h0, "R1 pin_oe");
    port(1, 32'h0, "R1 irq");
    @(negedge clk); rst_n = 1'b1;
    port(1, 32'h0, "R1 irq after reset");

    // quiet config: all pins high-level, pins held low
    wr(4'd2, 32'h5555_5555);
    wr(4'd3, 32'h5555_5555);
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, 32'h0, "R11 clear all");

    // R2 R3 R4 R5
    wr(4'd1, 32'h0000_FFFF);
    port(3, 32'h0000_FFFF, "R2 oe");
    wr(4'd0, 32'hA5A5_1234);
    port(2, 32'hA5A5_1234, "R2 pin_o");
    wr(4'd7, 32'h000F_0000);
    port(2, 32'hA5AF_1234, "R3 set alias");
    wr(4'd8, 32'h0000_0004);
    port(2, 32'hA5AF_1230, "R3 clear alias");
    rd(4'd7, 32'h0, "R4 set read");
    rd(4'd8, 32'h0, "R4 clear read");
    pin_in = 32'h1234_00FF;
    idle(3);
    rd(4'd0, 32'h1234_1230, "R5 mixed read");
    pin_in = 32'h0;
    idle(4);
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, 32'h0, "R11 clear after R5");

    // R6 R8 R9: pin 3 rising (cfg_lo bits 7:6), pin 20 falling (cfg_hi bits 9:8)
    wr(4'd2, 32'h5555_5595);
    wr(4'd3, 32'h5555_5755);
    pin_in = 32'h0010_0008;
    idle(4);
    rd(4'd5, 32'h0000_0008, "R8 R6 rise only pin3");
    wr(4'd5, 32'h0000_0008);
    idle(3);
    rd(4'd5, 32'h0, "R8 no retrigger");
    pin_in = 32'h0;
    idle(4);
    rd(4'd5, 32'h0010_0000, "R9 R6 fall only pin20");
    wr(4'd5, 32'hFFFF_FFFF);

    // R7 R11: pin 5 high level
    pin_in = 32'h0000_0020;
    idle(4);
    rd(4'd5, 32'h0000_0020, "R7 high level");
    wr(4'd5, 32'h0);
    rd(4'd5, 32'h0000_0020, "R11 zero write ignored");
    wr_rd(4'd5, 32'h0000_0020, 4'd5, 32'h0000_0020, "R11 event wins clear");
    pin_in = 32'h0;
    idle(4);
    wr_rd(4'd5, 32'h0000_0020, 4'd5, 32'h0, "R11 clear");
    // R7 low level on pin 7
    wr(4'd2, 32'h5555_1595);
    idle(2);
    rd(4'd5, 32'h0000_0080, "R7 low level");
    pin_in = 32'h0000_0080;
    idle(4);
    wr(4'd5, 32'h0000_0080);
    rd(4'd5, 32'h0, "R7 low level released");
    wr(4'd2, 32'h5555_5595);
    pin_in = 32'h0;
    idle(4);
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, 32'h0, "R11 clear before R10");

    // R10: pin 10 any-edge overrides high-level code
    wr(4'd6, 32'h0000_0400);
    pin_in = 32'h0000_0400;
    idle(4);
    rd(4'd5, 32'h0000_0400, "R10 rise");
    wr(4'd5, 32'h0000_0400);
    idle(2);
    rd(4'd5, 32'h0, "R10 code ignored");
    pin_in = 32'h0;
    idle(4);
    rd(4'd5, 32'h0000_0400, "R10 fall");

    // R12
    port(1, 32'h0, "R12 masked");
    wr(4'd4, 32'h0000_0800);
    port(1, 32'h0, "R12 other bit");
    wr(4'd4, 32'h0000_0400);
    port(1, 32'h1, "R12 unmasked");
    wr(4'd5, 32'h0000_0400);
    port(1, 32'h0, "R12 after clear");

    idle(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule